// File: doc/BRIEF.md
# Flash Self-Programming Command Controller

This block lets a processor rewrite its own program store. Software first writes a command pattern into an 8-bit control/status register. It then raises a store strobe. The controller accepts that strobe only if it comes within four clock cycles of the register write. An accepted command runs for a fixed number of cycles, either a page write or a lock-bit update. When it finishes, the controller clears the enable bit on its own.

The program store is modelled as a small array of pages, split into two regions. The lower pages can be rewritten while the CPU keeps running, so reads of that region are blocked during the update. The upper pages cannot be read while being written, so the CPU is halted for the whole operation. A busy flag for the lower region stays set after the write finishes. It clears only when software writes a re-enable command. A level interrupt reports that the controller is ready for the next command.

Top module: `flash_selfprog_ctrl`

## Requirements
- R1: After reset, the register reads 0x00, all six lock bits read 1 (unprogrammed), every page holds 0, and cpu_halt, irq and rww_read_block are low.
- R2: Register bit map: bit0 enable, bit2 page-write, bit3 lock-set, bit4 region re-enable, bit6 region-busy (read-only), bit7 interrupt enable. Bits 6:0 = 0000101 arm a page write and bits 6:0 = 0001001 arm a lock set. Any other pattern arms nothing and clears enable.
- R3: An armed command runs only if spm_strobe is high at one of the four rising edges after the register write. If no strobe arrives, enable and the armed bit clear at the fourth edge and nothing changes.
- R4: A page write targets page zaddr[9:7]. If any other zaddr bit is set, the command is dropped, enable clears and no page changes.
- R5: A lock set programs lock bit i for each r0_data[i] = 0 (i = 0..5) and ignores zaddr. A programmed lock bit never returns to 1.
- R6: A page write to pages 0–5 sets region-busy. While region-busy is set, reads of pages 0–5 give rd_valid = 0 and rd_data = 0, and pages 6–7 stay readable.
- R7: Region-busy stays set after the write completes. It clears only on a register write of pattern 0010001 (bits 6:0) while no operation runs.
- R8: A page write to pages 6–7 holds cpu_halt high from the strobe edge until completion. A write to pages 0–5 never raises cpu_halt.
- R9: A lock set raises neither cpu_halt nor region-busy.
- R10: irq is high exactly while the interrupt-enable bit is 1 and the enable bit is 0.
- R11: An accepted operation keeps enable high for PROG_CYCLES edges after the strobe edge. At the last of those edges, enable clears and the page data captured from buf_word (or the new lock value) takes effect.
- R12: Register writes while an operation runs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| csr_we | input | 1 | Control register write strobe |
| csr_wdata | input | 8 | Control register write data |
| csr_rdata | output | 8 | Control register read data |
| spm_strobe | input | 1 | Store-program-memory strobe |
| zaddr | input | ADDR_W | Address pointer, page field in bits 9:7 |
| r0_data | input | 8 | Lock value for lock-set commands |
| buf_word | input | DATA_W | Data written to the target page |
| rd_page | input | PAGE_BITS | Page read address |
| rd_data | output | DATA_W | Page read data |
| rd_valid | output | 1 | Read not blocked |
| lock_bits | output | 6 | Current lock bits (0 = programmed) |
| cpu_halt | output | 1 | CPU halt request |
| rww_read_block | output | 1 | Lower region reads blocked |
| irq | output | 1 | Ready interrupt (level) |

## Verification
A stuck or miscounted window counter shows on the enable bit of the register: enable drops one edge too early or late, or an op starts on a late strobe. The bench sees this within five cycles of the register write. A wrong operation counter moves the fall of enable and cpu_halt off the PROG_CYCLES edge. A corrupted target, region decode or lock merge shows up on the next read of every page and of lock_bits, right after completion. Region-busy and read blocking are checked both before and after the re-enable write.

// File: rtl/flash_selfprog_ctrl.sv
module flash_selfprog_ctrl #(
  parameter int ADDR_W      = 16,
  parameter int PAGE_LSB    = 7,
  parameter int PAGE_BITS   = 3,
  parameter int RWW_PAGES   = 6,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 csr_we,
  input  logic [7:0]           csr_wdata,
  output logic [7:0]           csr_rdata,
  input  logic                 spm_strobe,
  input  logic [ADDR_W-1:0]    zaddr,
  input  logic [7:0]           r0_data,
  input  logic [DATA_W-1:0]    buf_word,
  input  logic [PAGE_BITS-1:0] rd_page,
  output logic [DATA_W-1:0]    rd_data,
  output logic                 rd_valid,
  output logic [5:0]           lock_bits,
  output logic                 cpu_halt,
  output logic                 rww_read_block,
  output logic                 irq
);
  localparam int PAGES = 1 << PAGE_BITS;
  localparam int CNT_W = $clog2(PROG_CYCLES + 1);
  localparam logic [ADDR_W-1:0] PAGE_MASK = ADDR_W'(((1 << PAGE_BITS) - 1) << PAGE_LSB);
  localparam logic [PAGE_BITS:0] RWW_LIM = (PAGE_BITS + 1)'(RWW_PAGES);
  localparam logic [6:0] CMD_PW   = 7'b0000101;
  localparam logic [6:0] CMD_LOCK = 7'b0001001;
  localparam logic [6:0] CMD_REEN = 7'b0010001;

  logic en, pw_arm, lk_arm, ie, rww_busy;
  logic [2:0] win;
  logic op_act, op_lock, op_rww;
  logic [PAGE_BITS-1:0] op_page;
  logic [DATA_W-1:0] op_data;
  logic [5:0] op_r0, lock_q;
  logic [CNT_W-1:0] cnt;
  logic [DATA_W-1:0] mem [PAGES];

  wire [PAGE_BITS-1:0] z_page = zaddr[PAGE_LSB +: PAGE_BITS];
  wire z_clean  = (zaddr & ~PAGE_MASK) == '0;
  wire z_rww    = {1'b0, z_page} < RWW_LIM;
  wire rd_rww   = {1'b0, rd_page} < RWW_LIM;
  wire armed    = pw_arm | lk_arm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0; pw_arm <= 1'b0; lk_arm <= 1'b0; ie <= 1'b0; rww_busy <= 1'b0;
      win <= '0; op_act <= 1'b0; op_lock <= 1'b0; op_rww <= 1'b0;
      op_page <= '0; op_data <= '0; op_r0 <= '1; lock_q <= '1; cnt <= '0;
      for (int i = 0; i < PAGES; i++) mem[i] <= '0;
    end else if (op_act) begin
      if (cnt == CNT_W'(1)) begin
        op_act <= 1'b0;
        en     <= 1'b0;
        pw_arm <= 1'b0;
        lk_arm <= 1'b0;
        if (op_lock) lock_q <= lock_q & op_r0;
        else         mem[op_page] <= op_data;
      end else begin
        cnt <= cnt - CNT_W'(1);
      end
    end else if (csr_we) begin
      ie     <= csr_wdata[7];
      en     <= 1'b0;
      pw_arm <= 1'b0;
      lk_arm <= 1'b0;
      case (csr_wdata[6:0])
        CMD_PW:   begin en <= 1'b1; pw_arm <= 1'b1; win <= 3'd4; end
        CMD_LOCK: begin en <= 1'b1; lk_arm <= 1'b1; win <= 3'd4; end
        CMD_REEN: rww_busy <= 1'b0;
        default:  ;
      endcase
    end else if (armed) begin
      if (spm_strobe) begin
        if (lk_arm) begin
          op_act  <= 1'b1;
          op_lock <= 1'b1;
          op_rww  <= 1'b0;
          op_r0   <= r0_data[5:0];
          cnt     <= CNT_W'(PROG_CYCLES);
        end else if (z_clean) begin
          op_act  <= 1'b1;
          op_lock <= 1'b0;
          op_rww  <= z_rww;
          op_page <= z_page;
          op_data <= buf_word;
          cnt     <= CNT_W'(PROG_CYCLES);
          if (z_rww) rww_busy <= 1'b1;
        end else begin
          en <= 1'b0; pw_arm <= 1'b0; lk_arm <= 1'b0;
        end
      end else if (win == 3'd1) begin
        en <= 1'b0; pw_arm <= 1'b0; lk_arm <= 1'b0;
      end else begin
        win <= win - 3'd1;
      end
    end
  end

  assign csr_rdata      = {ie, rww_busy, 2'b00, lk_arm, pw_arm, 1'b0, en};
  assign lock_bits      = lock_q;
  assign cpu_halt       = op_act & ~op_lock & ~op_rww;
  assign rww_read_block = rww_busy;
  assign irq            = ie & ~en;
  assign rd_valid       = !(rd_rww && rww_busy);
  assign rd_data        = rd_valid ? mem[rd_page] : '0;
endmodule

// File: rtl/flash_selfprog_ctrl_chk.sv
module flash_selfprog_ctrl_chk #(
  parameter int PAGE_BITS = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 csr_we,
  input logic [7:0]           csr_rdata,
  input logic                 cpu_halt,
  input logic                 rww_read_block,
  input logic                 irq,
  input logic [5:0]           lock_bits,
  input logic                 rd_valid,
  input logic [PAGE_BITS-1:0] rd_page
);
  assert_irq_on_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(csr_rdata[0]) && csr_rdata[7]) |-> irq);

  assert_halt_ends_with_op_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_halt) |-> !csr_rdata[0]);

  assert_halt_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_halt |-> csr_rdata[0]);

  assert_lock_one_way_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_bits & ~$past(lock_bits)) == 6'd0);

  assert_busy_clears_on_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rww_read_block) |-> $past(csr_we));

  assert_block_only_when_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> rww_read_block);
endmodule

bind flash_selfprog_ctrl flash_selfprog_ctrl_chk #(.PAGE_BITS(PAGE_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_rdata(csr_rdata),
  .cpu_halt(cpu_halt), .rww_read_block(rww_read_block), .irq(irq),
  .lock_bits(lock_bits), .rd_valid(rd_valid), .rd_page(rd_page)
);

// File: tb/flash_selfprog_ctrl_test.sv
module flash_selfprog_ctrl_test;
  localparam int PROG = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic csr_we = 1'b0, spm_strobe = 1'b0;
  logic [7:0] csr_wdata = '0, r0_data = '0;
  logic [15:0] zaddr = '0, buf_word = '0;
  logic [2:0] rd_page = '0;
  logic [7:0] csr_rdata;
  logic [15:0] rd_data;
  logic rd_valid, cpu_halt, rww_read_block, irq;
  logic [5:0] lock_bits;
  int checks = 0, errors = 0;
  logic [15:0] exp_mem [8];
  logic [5:0] exp_lock;

  always #10 clk = ~clk;

  flash_selfprog_ctrl #(.PROG_CYCLES(PROG)) uut (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .spm_strobe(spm_strobe), .zaddr(zaddr), .r0_data(r0_data), .buf_word(buf_word),
    .rd_page(rd_page), .rd_data(rd_data), .rd_valid(rd_valid), .lock_bits(lock_bits),
    .cpu_halt(cpu_halt), .rww_read_block(rww_read_block), .irq(irq));

  // {cmd, strobe delay, zaddr, page data, lock value}
  localparam logic [50:0] VEC [9] = '{
    {8'h85, 3'd1, 16'h0080, 16'hA5A5, 8'hFF},
    {8'h85, 3'd4, 16'h0300, 16'h1234, 8'hFF},
    {8'h85, 3'd5, 16'h0100, 16'h5555, 8'hFF},
    {8'h85, 3'd2, 16'h0181, 16'h7777, 8'hFF},
    {8'h89, 3'd3, 16'hFFFF, 16'h0000, 8'hF6},
    {8'h05, 3'd1, 16'h0380, 16'hBEEF, 8'hFF},
    {8'h89, 3'd5, 16'h0000, 16'h0000, 8'h00},
    {8'h0D, 3'd1, 16'h0200, 16'h9999, 8'h00},
    {8'h89, 3'd4, 16'h0080, 16'h0000, 8'hFD}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic csr_write(input logic [7:0] d);
    @(negedge clk); csr_we = 1'b1; csr_wdata = d;
    @(negedge clk); csr_we = 1'b0;
  endtask

  task automatic check_pages(input string req);
    for (int p = 0; p < 8; p++) begin
      rd_page = 3'(p); #1;
      chk(rd_valid && rd_data == exp_mem[p], req, {15'd0, rd_valid, rd_data}, {16'd1, exp_mem[p]});
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int p = 0; p < 8; p++) exp_mem[p] = '0;
    exp_lock = 6'h3F;
    repeat (3) @(negedge clk);
    chk(csr_rdata == 8'h00 && lock_bits == 6'h3F, "R1", {csr_rdata, 2'b0, lock_bits}, {8'h00, 8'h3F});
    chk(!cpu_halt && !irq && !rww_read_block, "R1", {cpu_halt, irq, rww_read_block}, 0);
    rst_n = 1'b1;
    check_pages("R1");

    for (int i = 0; i < 9; i++) begin
      logic [50:0] v;
      logic [7:0] cmd;
      int dly;
      bit pw, lk, ok, rww;
      logic [2:0] pg;
      v = VEC[i];
      cmd = v[50:43]; dly = int'(v[42:40]);
      zaddr = v[39:24]; buf_word = v[23:8]; r0_data = v[7:0];
      pw = cmd[6:0] == 7'b0000101;
      lk = cmd[6:0] == 7'b0001001;
      pg = zaddr[9:7];
      rww = pg < 3'd6;
      ok = (pw || lk) && dly <= 4 && (lk || (zaddr & ~16'h0380) == 16'h0);
      csr_write(cmd);
      chk(csr_rdata[0] == (pw || lk), "R2", csr_rdata, {7'd0, pw || lk});
      repeat (dly - 1) @(negedge clk);
      spm_strobe = 1'b1;
      @(negedge clk); spm_strobe = 1'b0;
      if (ok) begin
        chk(cpu_halt == (pw && !rww), lk ? "R9" : "R8", cpu_halt, pw && !rww);
        chk(rww_read_block == (pw && rww), lk ? "R9" : "R6", rww_read_block, pw && rww);
        csr_write(8'h11);
        chk(csr_rdata[0] && csr_rdata[6] == (pw && rww), "R12", csr_rdata, {1'b0, pw && rww, 5'd0, 1'b1});
        repeat (PROG - 3) @(negedge clk);
        chk(csr_rdata[0] == 1'b1, "R11", csr_rdata[0], 1);
        chk(cpu_halt == (pw && !rww), "R8", cpu_halt, pw && !rww);
        @(negedge clk);
        chk(csr_rdata[0] == 1'b0 && !cpu_halt, "R11", {cpu_halt, csr_rdata[0]}, 0);
        if (pw) exp_mem[pg] = buf_word;
        else exp_lock = exp_lock & r0_data[5:0];
      end else begin
        chk(csr_rdata[0] == 1'b0 && !cpu_halt, (dly > 4) ? "R3" : "R4", {cpu_halt, csr_rdata[0]}, 0);
        repeat (PROG) @(negedge clk);
      end
      if (ok && pw && rww) begin
        chk(csr_rdata[6] == 1'b1, "R7", csr_rdata[6], 1);
        rd_page = pg; #1;
        chk(!rd_valid && rd_data == 16'h0, "R6", {rd_valid, rd_data}, 0);
        rd_page = 3'd6; #1;
        chk(rd_valid && rd_data == exp_mem[6], "R6", {rd_valid, rd_data}, {1'b1, exp_mem[6]});
        csr_write(8'h11);
        chk(csr_rdata[6] == 1'b0 && rww_read_block == 1'b0, "R7", csr_rdata, 0);
      end
      check_pages(lk ? "R5" : (ok ? "R11" : "R3"));
      chk(lock_bits == exp_lock, "R5", lock_bits, exp_lock);
    end

    csr_write(8'h85);
    chk(!irq, "R10", irq, 0);
    repeat (3) @(negedge clk);
    chk(csr_rdata[0] == 1'b1, "R3", csr_rdata[0], 1);
    @(negedge clk);
    chk(csr_rdata[0] == 1'b0 && irq, "R3", {irq, csr_rdata[0]}, 2'b10);
    csr_write(8'h05);
    chk(!irq, "R10", irq, 0);
    repeat (5) @(negedge clk);
    chk(!irq && csr_rdata[0] == 1'b0, "R10", {irq, csr_rdata[0]}, 0);
    csr_write(8'h80);
    chk(irq, "R10", irq, 1);

    r0_data = 8'hFF;
    csr_write(8'h09);
    spm_strobe = 1'b1;
    @(negedge clk); spm_strobe = 1'b0;
    repeat (PROG) @(negedge clk);
    chk(lock_bits == exp_lock, "R5", lock_bits, exp_lock);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule